// File: doc/BRIEF.md
# Prescaled Timer Counter with Flag Control

This block is a free-running 16-bit up-counter driven by a selectable prescaler. Software reaches it through a byte-wide register bus with eight addresses. An enable bit gates the counter and its prescaler. A debug-freeze input and a low-power wait input can each stop the timer when the matching control bit is set, but they stop different parts of it. The block also derives a divide-by-64 tick for a neighbouring pulse accumulator.

The block keeps six channel flags and one overflow flag. The capture and compare datapaths set the channel flags through event strobes. The block does not hold those datapaths, only their access strobes. Software clears flags by writing 1 to them. In fast-clear mode, flags also clear as a side effect of data accesses. Six output pins each invert on counter wrap when their enable bit is set. The prescaler mode bit accepts one write per reset.

Register map (byte address: content):
- 0, control: bit0 enable, bit1 stop-in-wait, bit2 stop-in-freeze, bit3 fast-clear, bit4 precision mode, bits 7..5 read 0.
- 1, configuration: bit0 overflow interrupt enable, bits 3..1 legacy divide select.
- 2: precision prescaler value.
- 3: counter high byte.
- 4: counter low byte.
- 5: channel flags, bits 5..0.
- 6: overflow flag, bit0.
- 7: toggle enables, bits 5..0.

Top module: `tmr_flag_timer`

## Requirements
- R1: After reset, every register reads 0 and the counter is 0. The timer is therefore disabled, in legacy mode, with fast clear off.
- R2: With control bit0 at 0, the counter and prescaler hold their values. With bit0 at 1, the counter advances once per prescaled tick. Writing address 3 or 4 loads that counter byte and takes precedence over counting.
- R3: With control bit4 at 0, one tick occurs every 2^S clocks, where S is configuration bits 3..1. With bit4 at 1, one tick occurs every P+1 clocks, where P is the byte at address 2.
- R4: `pa_tick` pulses for one clock in every 64 clocks while the timer runs, and stays low while it is stopped.
- R5: With control bit2 at 1 and `frz_i` high, the counter and its prescaler hold, while `pa_tick` keeps its 64-clock rhythm.
- R6: With control bit1 at 1 and `wait_i` high, the counter, prescaler and `pa_tick` all stop, and `ovf_irq` is held low.
- R7: Control bit4 takes its value only from the first write to address 0 after reset. Later writes leave it unchanged.
- R8: On the tick that takes the counter from 0xFFFF to 0x0000, the overflow flag (address 6 bit0) sets. `ovf_irq` equals that flag ANDed with configuration bit0.
- R9: On each wrap, every `tog_pins` bit whose toggle enable (address 7) is 1 inverts. Address 7 bits 7..6 read 0.
- R10: With fast clear off, writing 1 to a flag bit clears it and writing 0 has no effect. Capture reads, compare writes and counter accesses leave flags unchanged.
- R11: With control bit3 at 1, `ic_rd[i]` or `oc_wr[i]` clears channel flag i. Any read strobe or write at address 3 or 4 clears the overflow flag.
- R12: `ch_evt[i]` sets channel flag i, and a set wins over a clear in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 3 | Register address |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe (side effects only) |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr |
| frz_i | input | 1 | Debug freeze request |
| wait_i | input | 1 | Low-power wait request |
| ic_rd | input | 6 | Per-channel capture register read strobes |
| oc_wr | input | 6 | Per-channel compare register write strobes |
| ch_evt | input | 6 | Per-channel flag set events |
| count | output | 16 | Counter value |
| ch_flags | output | 6 | Channel flags |
| ovf_irq | output | 1 | Overflow interrupt request |
| tog_pins | output | 6 | Toggle-on-overflow outputs |
| pa_tick | output | 1 | Divide-by-64 tick for a pulse accumulator |

## Verification
A wrong prescaler phase or limit shows on `count` at the next expected tick, within at most 256 clocks. A wrong divider state shows on `pa_tick` within 64 clocks. A wrong flag shows at once on `ch_flags`, or on `ovf_irq` and address 6. A bad lock bit stays hidden until a later control write tries to change the mode, and then shows on the control readback. The reference model follows every register and counter cycle by cycle, so a divergence is reported in the cycle it first appears at a port.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

    typedef enum logic [2:0] {
        A_CTRL = 3'd0,
        A_CFG  = 3'd1,
        A_PRE  = 3'd2,
        A_CNTH = 3'd3,
        A_CNTL = 3'd4,
        A_CHF  = 3'd5,
        A_OVF  = 3'd6,
        A_TOG  = 3'd7
    } addr_e;

    typedef struct packed {
        logic precise;
        logic fastclr;
        logic stop_frz;
        logic stop_wait;
        logic en;
    } ctrl_t;

endpackage

// File: rtl/tmr_prescale.sv
module tmr_prescale #(
    parameter int PRE_W = 8,
    parameter int SEL_W = 3,
    parameter int PA_W  = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             cnt_run,
    input  logic             precise,
    input  logic [SEL_W-1:0] sel,
    input  logic [PRE_W-1:0] presc,
    output logic             step,
    output logic             pa_tick
);

    typedef struct packed {
        logic [PRE_W-1:0] pcnt;
        logic [PA_W-1:0]  padiv;
    } st_t;

    st_t s_d, s_q;
    logic [PRE_W-1:0] limit;

    always_comb begin
        s_d   = s_q;
        limit = precise ? presc : PRE_W'((32'd1 << sel) - 32'd1);
        step    = cnt_run && (s_q.pcnt == limit);
        pa_tick = run && (s_q.padiv == '1);
        if (cnt_run) s_d.pcnt = step ? '0 : s_q.pcnt + 1'b1;
        if (run)     s_d.padiv = s_q.padiv + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    p_halt_holds_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> ($stable(s_q.pcnt) && $stable(s_q.padiv)));

    p_freeze_keeps_pa_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !cnt_run) |=> ($stable(s_q.pcnt) && !$stable(s_q.padiv)));

endmodule

// File: rtl/tmr_count.sv
module tmr_count #(
    parameter int CNT_W = 16,
    parameter int NCH   = 6
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               step,
    input  logic               ld_hi,
    input  logic               ld_lo,
    input  logic [CNT_W/2-1:0] wbyte,
    input  logic [NCH-1:0]     tog_en,
    output logic [CNT_W-1:0]   cnt,
    output logic               wrap,
    output logic [NCH-1:0]     pins
);

    localparam int HALF = CNT_W / 2;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [NCH-1:0]   pins;
    } st_t;

    st_t s_d, s_q;

    always_comb begin
        s_d  = s_q;
        wrap = step && (s_q.cnt == '1) && !ld_hi && !ld_lo;
        if (ld_hi)  s_d.cnt[CNT_W-1:HALF] = wbyte;
        if (ld_lo)  s_d.cnt[HALF-1:0]     = wbyte;
        if (!ld_hi && !ld_lo && step) s_d.cnt = s_q.cnt + 1'b1;
        if (wrap)   s_d.pins = s_q.pins ^ tog_en;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign cnt  = s_q.cnt;
    assign pins = s_q.pins;

    p_count_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!step && !ld_hi && !ld_lo) |=> $stable(cnt));

    p_wrap_to_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        wrap |=> (cnt == '0));

    p_pins_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !wrap |=> $stable(pins));

endmodule

// File: rtl/tmr_flags.sv
module tmr_flags #(
    parameter int NCH = 6
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NCH-1:0] ch_set,
    input  logic [NCH-1:0] ch_clr,
    input  logic           ovf_set,
    input  logic           ovf_clr,
    output logic [NCH-1:0] ch_flag,
    output logic           ovf_flag
);

    typedef struct packed {
        logic [NCH-1:0] ch;
        logic           ovf;
    } st_t;

    st_t s_d, s_q;

    always_comb begin
        s_d     = s_q;
        s_d.ch  = (s_q.ch & ~ch_clr) | ch_set;
        s_d.ovf = (s_q.ovf & !ovf_clr) | ovf_set;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign ch_flag  = s_q.ch;
    assign ovf_flag = s_q.ovf;

    for (genvar i = 0; i < NCH; i++) begin : g_chk
        p_set_wins_r12: assert property (@(posedge clk) disable iff (!rst_n)
            ch_set[i] |=> ch_flag[i]);
        p_clear_takes_r10: assert property (@(posedge clk) disable iff (!rst_n)
            (ch_clr[i] && !ch_set[i]) |=> !ch_flag[i]);
    end

    p_ovf_sets_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_set |=> ovf_flag);

endmodule

// File: rtl/tmr_flag_timer.sv
module tmr_flag_timer
    import tmr_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter int NCH   = 6,
    parameter int PRE_W = 8,
    parameter int SEL_W = 3,
    parameter int PA_W  = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [2:0]       bus_addr,
    input  logic             bus_wr,
    input  logic             bus_rd,
    input  logic [7:0]       bus_wdata,
    output logic [7:0]       bus_rdata,
    input  logic             frz_i,
    input  logic             wait_i,
    input  logic [NCH-1:0]   ic_rd,
    input  logic [NCH-1:0]   oc_wr,
    input  logic [NCH-1:0]   ch_evt,
    output logic [CNT_W-1:0] count,
    output logic [NCH-1:0]   ch_flags,
    output logic             ovf_irq,
    output logic [NCH-1:0]   tog_pins,
    output logic             pa_tick
);

    localparam int BW = 8;

    typedef struct packed {
        ctrl_t            ctrl;
        logic             locked;
        logic             ovf_ie;
        logic [SEL_W-1:0] sel;
        logic [PRE_W-1:0] presc;
        logic [NCH-1:0]   tog;
    } regs_t;

    regs_t r_d, r_q;

    logic           run, cnt_run, wait_stop, step, wrap, ovf_flag;
    logic           ld_hi, ld_lo, cnt_acc, ovf_clr;
    logic [NCH-1:0] ch_clr;
    addr_e          a;

    assign a = addr_e'(bus_addr);

    always_comb begin
        r_d = r_q;
        if (bus_wr) begin
            case (a)
                A_CTRL: begin
                    r_d.ctrl.en        = bus_wdata[0];
                    r_d.ctrl.stop_wait = bus_wdata[1];
                    r_d.ctrl.stop_frz  = bus_wdata[2];
                    r_d.ctrl.fastclr   = bus_wdata[3];
                    if (!r_q.locked) r_d.ctrl.precise = bus_wdata[4];
                    r_d.locked = 1'b1;
                end
                A_CFG: begin
                    r_d.ovf_ie = bus_wdata[0];
                    r_d.sel    = bus_wdata[SEL_W:1];
                end
                A_PRE:   r_d.presc = bus_wdata[PRE_W-1:0];
                A_TOG:   r_d.tog   = bus_wdata[NCH-1:0];
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign wait_stop = r_q.ctrl.stop_wait && wait_i;
    assign run       = r_q.ctrl.en && !wait_stop;
    assign cnt_run   = run && !(r_q.ctrl.stop_frz && frz_i);

    assign ld_hi   = bus_wr && (a == A_CNTH);
    assign ld_lo   = bus_wr && (a == A_CNTL);
    assign cnt_acc = (bus_wr || bus_rd) && ((a == A_CNTH) || (a == A_CNTL));

    always_comb begin
        ch_clr = (bus_wr && a == A_CHF) ? bus_wdata[NCH-1:0] : '0;
        if (r_q.ctrl.fastclr) ch_clr = ch_clr | ic_rd | oc_wr;
        ovf_clr = (bus_wr && a == A_OVF && bus_wdata[0]) ||
                  (r_q.ctrl.fastclr && cnt_acc);
    end

    tmr_prescale #(.PRE_W(PRE_W), .SEL_W(SEL_W), .PA_W(PA_W)) u_pre (
        .clk(clk), .rst_n(rst_n), .run(run), .cnt_run(cnt_run),
        .precise(r_q.ctrl.precise), .sel(r_q.sel), .presc(r_q.presc),
        .step(step), .pa_tick(pa_tick)
    );

    tmr_count #(.CNT_W(CNT_W), .NCH(NCH)) u_cnt (
        .clk(clk), .rst_n(rst_n), .step(step), .ld_hi(ld_hi), .ld_lo(ld_lo),
        .wbyte(bus_wdata), .tog_en(r_q.tog), .cnt(count), .wrap(wrap),
        .pins(tog_pins)
    );

    tmr_flags #(.NCH(NCH)) u_flg (
        .clk(clk), .rst_n(rst_n), .ch_set(ch_evt), .ch_clr(ch_clr),
        .ovf_set(wrap), .ovf_clr(ovf_clr), .ch_flag(ch_flags),
        .ovf_flag(ovf_flag)
    );

    assign ovf_irq = ovf_flag && r_q.ovf_ie && !wait_stop;

    always_comb begin
        case (a)
            A_CTRL:  bus_rdata = BW'({r_q.ctrl.precise, r_q.ctrl.fastclr,
                                      r_q.ctrl.stop_frz, r_q.ctrl.stop_wait,
                                      r_q.ctrl.en});
            A_CFG:   bus_rdata = BW'({r_q.sel, r_q.ovf_ie});
            A_PRE:   bus_rdata = BW'(r_q.presc);
            A_CNTH:  bus_rdata = count[CNT_W-1:BW];
            A_CNTL:  bus_rdata = count[BW-1:0];
            A_CHF:   bus_rdata = BW'(ch_flags);
            A_OVF:   bus_rdata = BW'(ovf_flag);
            default: bus_rdata = BW'(r_q.tog);
        endcase
    end

    p_irq_masked_wait_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.ctrl.stop_wait && wait_i) |-> !ovf_irq);

    p_mode_locked_r7: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.locked |=> $stable(r_q.ctrl.precise));

    p_tog_reserved_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (a == A_TOG) |-> ((bus_rdata >> NCH) == '0));

endmodule

// File: tb/tmr_flag_timer_bench.sv
`timescale 1ns/1ps
module tmr_flag_timer_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  bus_addr = '0;
    logic        bus_wr = 1'b0, bus_rd = 1'b0;
    logic [7:0]  bus_wdata = '0;
    logic [7:0]  bus_rdata;
    logic        frz_i = 1'b0, wait_i = 1'b0;
    logic [5:0]  ic_rd = '0, oc_wr = '0, ch_evt = '0;
    logic [15:0] count;
    logic [5:0]  ch_flags, tog_pins;
    logic        ovf_irq, pa_tick;

    always #10 clk = ~clk;

    tmr_flag_timer u_tmr_flag_timer (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .frz_i(frz_i), .wait_i(wait_i), .ic_rd(ic_rd), .oc_wr(oc_wr),
        .ch_evt(ch_evt), .count(count), .ch_flags(ch_flags),
        .ovf_irq(ovf_irq), .tog_pins(tog_pins), .pa_tick(pa_tick)
    );

    int n_cmp = 0, n_bad = 0, pa_seen = 0;
    bit done = 0;

    task automatic chk(string tag, int act, int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // reference model state
    int m_en, m_sw, m_sf, m_fc, m_pr, m_lock, m_ie, m_sel, m_pre;
    int m_pcnt, m_pa, m_cnt, m_chf, m_ovf, m_tog, m_pins;

    task automatic m_reset();
        m_en = 0; m_sw = 0; m_sf = 0; m_fc = 0; m_pr = 0; m_lock = 0;
        m_ie = 0; m_sel = 0; m_pre = 0; m_pcnt = 0; m_pa = 0; m_cnt = 0;
        m_chf = 0; m_ovf = 0; m_tog = 0; m_pins = 0;
    endtask

    function automatic int m_run();
        return (m_en != 0 && !(m_sw != 0 && wait_i)) ? 1 : 0;
    endfunction

    function automatic int exp_rdata(int a);
        case (a)
            0: return (m_pr << 4) | (m_fc << 3) | (m_sf << 2) | (m_sw << 1) | m_en;
            1: return (m_sel << 1) | m_ie;
            2: return m_pre;
            3: return m_cnt >> 8;
            4: return m_cnt & 255;
            5: return m_chf;
            6: return m_ovf;
            default: return m_tog;
        endcase
    endfunction

    initial m_reset();

    always @(posedge clk) begin : mdl
        int run, crun, lim, stp, ldh, ldl, wrp, chclr, ovclr, wd, a;
        if (!rst_n) m_reset();
        else begin
            wd   = int'(bus_wdata);
            a    = int'(bus_addr);
            run  = m_run();
            crun = (run != 0 && !(m_sf != 0 && frz_i)) ? 1 : 0;
            lim  = (m_pr != 0) ? m_pre : (1 << m_sel) - 1;
            stp  = (crun != 0 && m_pcnt == lim) ? 1 : 0;
            if (crun != 0) m_pcnt = (stp != 0) ? 0 : (m_pcnt + 1) % 256;
            if (run != 0)  m_pa = (m_pa + 1) % 64;
            ldh = (bus_wr && a == 3) ? 1 : 0;
            ldl = (bus_wr && a == 4) ? 1 : 0;
            wrp = (stp != 0 && m_cnt == 65535 && ldh == 0 && ldl == 0) ? 1 : 0;
            if (ldh != 0) m_cnt = (m_cnt & 'hFF) | (wd << 8);
            if (ldl != 0) m_cnt = (m_cnt & 'hFF00) | wd;
            if (ldh == 0 && ldl == 0 && stp != 0) m_cnt = (m_cnt + 1) % 65536;
            if (wrp != 0) m_pins = m_pins ^ m_tog;
            chclr = (bus_wr && a == 5) ? (wd & 63) : 0;
            if (m_fc != 0) chclr = chclr | int'(ic_rd) | int'(oc_wr);
            ovclr = ((bus_wr && a == 6 && bus_wdata[0]) ||
                     (m_fc != 0 && (bus_wr || bus_rd) && (a == 3 || a == 4))) ? 1 : 0;
            m_chf = (m_chf & ~chclr & 63) | int'(ch_evt);
            m_ovf = ((m_ovf != 0 && ovclr == 0) || wrp != 0) ? 1 : 0;
            if (bus_wr) begin
                case (a)
                    0: begin
                        m_en = wd & 1; m_sw = (wd >> 1) & 1;
                        m_sf = (wd >> 2) & 1; m_fc = (wd >> 3) & 1;
                        if (m_lock == 0) m_pr = (wd >> 4) & 1;
                        m_lock = 1;
                    end
                    1: begin m_ie = wd & 1; m_sel = (wd >> 1) & 7; end
                    2: m_pre = wd;
                    7: m_tog = wd & 63;
                    default: ;
                endcase
            end
        end
    end

    // per-cycle comparison away from the active edge
    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk("R2 count", int'(count), m_cnt);
            chk("R9 tog_pins", int'(tog_pins), m_pins);
            chk("R10 ch_flags", int'(ch_flags), m_chf);
            chk("R4 pa_tick", int'(pa_tick), (m_run() != 0 && m_pa == 63) ? 1 : 0);
            chk("R8 ovf_irq", int'(ovf_irq),
                (m_ovf != 0 && m_ie != 0 && !(m_sw != 0 && wait_i)) ? 1 : 0);
            chk("R1 bus_rdata", int'(bus_rdata), exp_rdata(int'(bus_addr)));
            if (pa_tick) pa_seen++;
        end
    end

    task automatic tick(int n = 1);
        repeat (n) begin @(posedge clk); #3; end
    endtask

    task automatic wr(int a, int d);
        bus_addr = 3'(a); bus_wdata = 8'(d); bus_wr = 1'b1;
        tick();
        bus_wr = 1'b0;
    endtask

    task automatic rd(int a, bit strobe, output int v);
        bus_addr = 3'(a); bus_rd = strobe;
        #1 v = int'(bus_rdata);
        tick();
        bus_rd = 1'b0;
    endtask

    initial begin
        #4000000;
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog expired");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        int v, c0, p0;
        repeat (3) @(posedge clk);
        #3 rst_n = 1'b1;
        tick();
        for (int a = 0; a < 8; a++) begin
            rd(a, 1'b0, v); chk("R1 reset register", v, 0);
        end
        tick(50);
        chk("R2 disabled counter", int'(count), 0);

        // precision prescaler, divide by 3
        wr(2, 2); wr(1, 1); wr(0, 'h11);
        tick(5); #1 c0 = int'(count);
        tick(30); #1 chk("R3 precise divide", int'(count) - c0, 10);
        rd(0, 1'b0, v); chk("R7 first write", v, 'h11);
        wr(0, 'h01);
        rd(0, 1'b0, v); chk("R7 later write ignored", v, 'h11);

        // disabled
        wr(0, 'h10);
        #1 c0 = int'(count); p0 = pa_seen;
        tick(100);
        #1 chk("R2 hold when off", int'(count), c0);
        chk("R4 no pa tick when off", pa_seen - p0, 0);

        // freeze
        wr(0, 'h15); frz_i = 1'b1;
        #1 c0 = int'(count); p0 = pa_seen;
        tick(256);
        #1 chk("R5 counter frozen", int'(count), c0);
        chk("R5 pa tick continues", pa_seen - p0, 4);
        frz_i = 1'b0;

        // wait
        wr(0, 'h13); wait_i = 1'b1;
        #1 c0 = int'(count); p0 = pa_seen;
        tick(256);
        #1 chk("R6 counter stopped", int'(count), c0);
        chk("R6 pa tick stopped", pa_seen - p0, 0);
        wait_i = 1'b0;

        // overflow and toggles
        wr(7, 'hFF);
        rd(7, 1'b0, v); chk("R9 reserved bits", v, 'h3F);
        wr(7, 'h2D); wr(0, 'h11);
        wr(3, 'hFF); wr(4, 'hF0);
        tick(80);
        rd(6, 1'b0, v); chk("R8 overflow flag", v, 1);
        #1 chk("R9 pins toggled", int'(tog_pins), 'h2D);
        chk("R8 irq raised", int'(ovf_irq), 1);
        wait_i = 1'b1; wr(0, 'h13);
        #1 chk("R6 irq masked in wait", int'(ovf_irq), 0);
        wait_i = 1'b0; wr(0, 'h11);

        // normal clearing
        rd(3, 1'b1, v);
        rd(6, 1'b0, v); chk("R10 access no clear", v, 1);
        wr(6, 0);
        rd(6, 1'b0, v); chk("R10 write 0 no effect", v, 1);
        wr(6, 1);
        rd(6, 1'b0, v); chk("R10 write 1 clears", v, 0);
        ch_evt = 6'h3F; tick(); ch_evt = '0;
        #1 chk("R12 events set", int'(ch_flags), 'h3F);
        ic_rd = 6'h01; tick(); ic_rd = '0;
        #1 chk("R10 capture read no clear", int'(ch_flags), 'h3F);
        wr(5, 2);
        #1 chk("R10 write clears bit1", int'(ch_flags), 'h3D);

        // fast clear
        wr(0, 'h19);
        ic_rd = 6'h04; tick(); ic_rd = '0;
        #1 chk("R11 capture read clears", int'(ch_flags), 'h39);
        oc_wr = 6'h08; tick(); oc_wr = '0;
        #1 chk("R11 compare write clears", int'(ch_flags), 'h31);
        wr(3, 'hFF); wr(4, 'hFE);
        tick(20);
        rd(6, 1'b0, v); chk("R8 second overflow", v, 1);
        rd(4, 1'b1, v);
        rd(6, 1'b0, v); chk("R11 counter read clears", v, 0);
        ch_evt = 6'h01; bus_addr = 3'd5; bus_wdata = 8'h01; bus_wr = 1'b1;
        tick(); bus_wr = 1'b0; ch_evt = '0;
        #1 chk("R12 set wins", int'(ch_flags), 'h31);

        // legacy prescaler after a fresh reset
        rst_n = 1'b0; tick(2); rst_n = 1'b1; tick();
        wr(1, 'h06); wr(0, 'h01);
        wr(0, 'h11);
        rd(0, 1'b0, v); chk("R7 mode stays legacy", v, 'h01);
        tick(5); #1 c0 = int'(count);
        tick(64); #1 chk("R3 legacy divide by 8", int'(count) - c0, 8);

        tick(2);
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule